// File: doc/BRIEF.md
# Write-Protection Command Sequence Detector

This block sits beside the page loader of a paged nonvolatile memory and inspects every latched write cycle, meaning the address and the data byte captured for one byte load. It looks for two fixed address/data sequences. The first is a three-byte prefix that either turns write protection on or, when protection is already on, unlocks the current load. The second is a six-byte sequence that turns protection off. For each write the block tells the loader at once whether that byte is command data, which must never reach the array, or ordinary data.

A persistent protection flag changes only when a write period completes. Enabling takes effect at the end of the write period that follows the enable prefix, even if that load carried no data bytes. Disabling works the same way. While protection is on, a load that lacks a complete prefix still runs its normal write period, but the block holds a commit-block output high so that nothing is stored. The flag is cleared only by the power-on reset. A warm reset clears the sequence matcher and the per-load state and leaves the flag unchanged.

Top module: `wp_seq_guard`

## Requirements
- R1: After power-on reset, `prot_on_o`, `commit_block_o` and `cmd_byte_o` are all 0.
- R2: In the same cycle as the write, `cmd_byte_o` is 1 for each byte of the prefix: data 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. Only address bits 14..0 are compared, so bits above 14 have no effect.
- R3: Once a prefix is complete, every further byte of the same load is ordinary data (`cmd_byte_o` = 0).
- R4: A byte that does not match the expected step is ordinary data (`cmd_byte_o` = 0), and the matcher returns to the first step. A byte that would only be valid at a later step is therefore also data.
- R5: After an enable prefix, `prot_on_o` rises in the cycle after `prog_done` closes that write period, even when no data byte followed the prefix. Before that cycle it does not rise.
- R6: The six-byte sequence 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555 is flagged as command data byte by byte. `prot_on_o` falls in the cycle after `prog_done` of that load.
- R7: While protection is on and the current load has no complete prefix, `commit_block_o` is 1. This includes loads of ordinary data, which still run their write period.
- R8: While protection is on, `commit_block_o` falls in the cycle after the final prefix byte. It stays 0 until `prog_done`, then returns to 1.
- R9: A pulse on `rst_n` clears the matcher and any unlock but leaves `prot_on_o` unchanged. A pulse on `por_n` clears `prot_on_o`.
- R10: Writes presented between `load_end` and `prog_done` are ignored: `cmd_byte_o` stays 0 and the matcher does not advance.
- R11: `load_end` returns the matcher to its first step, so a partial prefix does not carry over into the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears everything including the flag |
| rst_n | input | 1 | Warm reset, active low, synchronous; keeps the protection flag |
| wr_valid | input | 1 | One latched byte load this cycle |
| wr_addr | input | ADDR_W (17) | Latched address of the byte |
| wr_data | input | 8 | Latched data byte |
| load_end | input | 1 | Byte-load window closed; write period starts |
| prog_done | input | 1 | Write period finished |
| cmd_byte_o | output | 1 | Current byte is command data; do not store |
| commit_block_o | output | 1 | Suppress array commits for the current load |
| prot_on_o | output | 1 | Protection flag |

## Verification
`cmd_byte_o` is combinational and is due in the cycle of the write itself. The bench samples it one nanosecond after driving the inputs, before the next rising edge. `commit_block_o` and `prot_on_o` come from registers and are due one edge after the write, `load_end` or `prog_done` that moves them. The bench samples them at the falling edge that follows that rising edge. Each table vector records both the same-cycle expectation and the post-edge expectation, and the directed tests use the same two sampling points.

// File: rtl/wp_seq_pkg.sv
package wp_seq_pkg;
  localparam int CMD_AW  = 15;
  localparam int BYTE_W  = 8;
  localparam int NSTEP   = 6;
  localparam logic [BYTE_W-1:0] ALT_BYTE = 8'h80;

  typedef enum logic [2:0] {
    ST_0, ST_1, ST_2, ST_3, ST_4, ST_5, ST_DONE
  } step_t;

  localparam int NIDX = 1 << $bits(step_t);

  // address expected at a step: the two command addresses alternate
  function automatic logic [CMD_AW-1:0] step_addr(input int idx);
    case (idx)
      1, 4:    step_addr = 15'h2AAA;
      default: step_addr = 15'h5555;
    endcase
  endfunction

  // data expected at a step (step 2 also accepts ALT_BYTE)
  function automatic logic [BYTE_W-1:0] step_byte(input int idx);
    case (idx)
      1, 4:    step_byte = 8'h55;
      2:       step_byte = 8'hA0;
      5:       step_byte = 8'h20;
      default: step_byte = 8'hAA;
    endcase
  endfunction
endpackage

// File: rtl/wp_seq_matcher.sv
module wp_seq_matcher
  import wp_seq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              load_end,
  input  logic              busy,
  output logic              cmd_byte,
  output logic              unlock_hit,
  output logic              disable_hit
);
  logic [CMD_AW-1:0] low_addr;
  logic [NIDX-1:0]   step_ok;
  step_t             step_q, step_d;
  logic              live, hit, is_alt;

  assign low_addr = wr_addr[CMD_AW-1:0];
  assign is_alt   = (wr_data == ALT_BYTE);

  for (genvar g = 0; g < NIDX; g++) begin : g_cmp
    if (g < NSTEP) begin : g_real
      if (g == 2) begin : g_branch
        assign step_ok[g] = (low_addr == step_addr(g)) &&
                            ((wr_data == step_byte(g)) || is_alt);
      end else begin : g_plain
        assign step_ok[g] = (low_addr == step_addr(g)) &&
                            (wr_data == step_byte(g));
      end
    end else begin : g_pad
      assign step_ok[g] = 1'b0;
    end
  end

  assign live        = wr_valid && !busy && (step_q != ST_DONE);
  assign hit         = live && step_ok[step_q];
  assign cmd_byte    = hit;
  assign unlock_hit  = hit && (step_q == ST_2) && !is_alt;
  assign disable_hit = hit && (step_q == ST_5);

  always_comb begin
    step_d = step_q;
    if (load_end) begin
      step_d = ST_0;
    end else if (hit) begin
      case (step_q)
        ST_2:    step_d = is_alt ? ST_3 : ST_DONE;
        ST_5:    step_d = ST_DONE;
        default: step_d = step_t'(step_q + 3'd1);
      endcase
    end else if (live) begin
      step_d = ST_0;
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n || !rst_n) step_q <= ST_0;
    else                  step_q <= step_d;
  end

  // R4: a live byte that is not a command sends the matcher back to step 0
  a_r4_break_restarts: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (live && !cmd_byte && !load_end) |=> (step_q == ST_0));
  // R11: closing a load always restarts the matcher
  a_r11_load_end_restart: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    load_end |=> (step_q == ST_0));
endmodule

// File: rtl/wp_prot_state.sv
module wp_prot_state (
  input  logic clk,
  input  logic por_n,
  input  logic rst_n,
  input  logic load_end,
  input  logic prog_done,
  input  logic unlock_hit,
  input  logic disable_hit,
  output logic busy,
  output logic commit_block,
  output logic prot_on
);
  logic prot_q, pend_en_q, pend_dis_q, unlocked_q, busy_q;
  logic period_end;

  assign period_end   = prog_done && busy_q;
  assign busy         = busy_q;
  assign prot_on      = prot_q;
  assign commit_block = prot_q && !unlocked_q;

  // flag: only power-on reset clears it
  always_ff @(posedge clk) begin
    if (!por_n)                       prot_q <= 1'b0;
    else if (period_end && pend_dis_q) prot_q <= 1'b0;
    else if (period_end && pend_en_q)  prot_q <= 1'b1;
  end

  // per-load state: cleared by either reset
  always_ff @(posedge clk) begin
    if (!por_n || !rst_n) begin
      pend_en_q  <= 1'b0;
      pend_dis_q <= 1'b0;
      unlocked_q <= 1'b0;
      busy_q     <= 1'b0;
    end else if (period_end) begin
      pend_en_q  <= 1'b0;
      pend_dis_q <= 1'b0;
      unlocked_q <= 1'b0;
      busy_q     <= 1'b0;
    end else begin
      if (load_end)    busy_q     <= 1'b1;
      if (unlock_hit)  pend_en_q  <= 1'b1;
      if (disable_hit) pend_dis_q <= 1'b1;
      if (unlock_hit || disable_hit) unlocked_q <= 1'b1;
    end
  end

  // R5: the flag moves only at the end of a write period
  a_r5_flag_on_period_end: assert property (@(posedge clk) disable iff (!por_n)
    !period_end |=> $stable(prot_q));
  // R6: a pending disable always wins at period end
  a_r6_disable_clears: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (period_end && pend_dis_q) |=> !prot_on);
endmodule

// File: rtl/wp_seq_guard.sv
module wp_seq_guard
  import wp_seq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              load_end,
  input  logic              prog_done,
  output logic              cmd_byte_o,
  output logic              commit_block_o,
  output logic              prot_on_o
);
  logic busy, unlock_hit, disable_hit;

  wp_seq_matcher #(.ADDR_W(ADDR_W)) u_match (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_end(load_end), .busy(busy),
    .cmd_byte(cmd_byte_o), .unlock_hit(unlock_hit), .disable_hit(disable_hit)
  );

  wp_prot_state u_state (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .load_end(load_end), .prog_done(prog_done),
    .unlock_hit(unlock_hit), .disable_hit(disable_hit),
    .busy(busy), .commit_block(commit_block_o), .prot_on(prot_on_o)
  );

  // R10: no command byte is recognised during a write period
  a_r10_busy_quiet: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    busy |-> !cmd_byte_o);
  // R8: a completed prefix lifts the commit block on the next cycle
  a_r8_prefix_lifts: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (unlock_hit && !prog_done) |=> !commit_block_o);
  // R2: a command byte is only reported for a presented write
  a_r2_cmd_needs_write: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    cmd_byte_o |-> wr_valid);
endmodule

// File: tb/wp_seq_guard_tb.sv
module wp_seq_guard_tb;
  logic        clk = 1'b0;
  logic        por_n = 1'b0, rst_n = 1'b1;
  logic        wr_valid = 1'b0, load_end = 1'b0, prog_done = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        cmd_byte_o, commit_block_o, prot_on_o;
  int          errors = 0, checks = 0;

  always #2 clk = ~clk; // 250 MHz

  wp_seq_guard u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .load_end(load_end),
    .prog_done(prog_done), .cmd_byte_o(cmd_byte_o),
    .commit_block_o(commit_block_o), .prot_on_o(prot_on_o)
  );

  // op[29:28] 0=write 1=load_end 2=prog_done, addr[27:11], data[10:3],
  // expected cmd[2] (same cycle), commit_block[1] and prot[0] (after edge)
  localparam int NV = 30;
  localparam logic [29:0] VEC [NV] = '{
    {2'd0,17'h05555,8'hAA,3'b100}, {2'd0,17'h02AAA,8'h55,3'b100},
    {2'd0,17'h05555,8'hA0,3'b100}, {2'd1,17'h00000,8'h00,3'b000},
    {2'd2,17'h00000,8'h00,3'b011}, {2'd0,17'h00040,8'h12,3'b011},
    {2'd1,17'h00000,8'h00,3'b011}, {2'd2,17'h00000,8'h00,3'b011},
    {2'd0,17'h1D555,8'hAA,3'b111}, {2'd0,17'h02AAA,8'h55,3'b111},
    {2'd0,17'h05555,8'hA0,3'b101}, {2'd0,17'h00100,8'h34,3'b001},
    {2'd1,17'h00000,8'h00,3'b001}, {2'd2,17'h00000,8'h00,3'b011},
    {2'd0,17'h05555,8'hAA,3'b111}, {2'd0,17'h02AAA,8'h77,3'b011},
    {2'd0,17'h02AAA,8'h55,3'b011}, {2'd1,17'h00000,8'h00,3'b011},
    {2'd2,17'h00000,8'h00,3'b011}, {2'd0,17'h05555,8'hAA,3'b111},
    {2'd0,17'h02AAA,8'h55,3'b111}, {2'd0,17'h05555,8'h80,3'b111},
    {2'd0,17'h05555,8'hAA,3'b111}, {2'd0,17'h02AAA,8'h55,3'b111},
    {2'd0,17'h05555,8'h20,3'b101}, {2'd1,17'h00000,8'h00,3'b001},
    {2'd2,17'h00000,8'h00,3'b000}, {2'd0,17'h05555,8'h56,3'b000},
    {2'd1,17'h00000,8'h00,3'b000}, {2'd2,17'h00000,8'h00,3'b000}
  };

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, got, exp);
    end
  endtask

  // drive one op at a falling edge; check cmd now, registered outputs after the edge
  task automatic apply(input string req, input logic [1:0] op, input logic [16:0] a,
                       input logic [7:0] d, input logic ecmd, input logic esup,
                       input logic eprot, input logic chk_reg);
    wr_valid  = (op == 2'd0);
    load_end  = (op == 2'd1);
    prog_done = (op == 2'd2);
    wr_addr   = a;
    wr_data   = d;
    #1;
    if (op == 2'd0) chk(req, "cmd_byte_o", cmd_byte_o, ecmd);
    @(negedge clk);
    wr_valid = 1'b0; load_end = 1'b0; prog_done = 1'b0;
    if (chk_reg) begin
      chk(req, "commit_block_o", commit_block_o, esup);
      chk(req, "prot_on_o", prot_on_o, eprot);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "prot_on_o", prot_on_o, 1'b0);
    chk("R1", "commit_block_o", commit_block_o, 1'b0);
    chk("R1", "cmd_byte_o", cmd_byte_o, 1'b0);

    // table walk: R2 prefix/upper bits, R3 data after prefix, R4 breaks,
    // R5 enable, R6 disable, R7 blocked load, R8 unlocked load
    for (int i = 0; i < NV; i++) begin
      logic [29:0] v;
      v = VEC[i];
      apply("R2-R8 table", v[29:28], v[27:11], v[10:3], v[2], v[1], v[0], 1'b1);
    end

    // R10: writes during the write period are ignored; R11: restart per load
    apply("R2",  2'd0, 17'h05555, 8'hAA, 1'b1, 1'b0, 1'b0, 1'b1);
    apply("R11", 2'd1, 17'h0,     8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
    apply("R10", 2'd0, 17'h02AAA, 8'h55, 1'b0, 1'b0, 1'b0, 1'b1);
    apply("R10", 2'd2, 17'h0,     8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
    apply("R11", 2'd0, 17'h02AAA, 8'h55, 1'b0, 1'b0, 1'b0, 1'b1);
    apply("R11", 2'd0, 17'h05555, 8'hA0, 1'b0, 1'b0, 1'b0, 1'b1);
    apply("R11", 2'd1, 17'h0,     8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
    apply("R11", 2'd2, 17'h0,     8'h00, 1'b0, 1'b0, 1'b0, 1'b1);

    // R5 again, then R9 warm reset keeps the flag, power-on reset clears it
    apply("R5", 2'd0, 17'h05555, 8'hAA, 1'b1, 1'b0, 1'b0, 1'b1);
    apply("R5", 2'd0, 17'h02AAA, 8'h55, 1'b1, 1'b0, 1'b0, 1'b1);
    apply("R5", 2'd0, 17'h05555, 8'hA0, 1'b1, 1'b0, 1'b0, 1'b1);
    apply("R5", 2'd1, 17'h0,     8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
    apply("R5", 2'd2, 17'h0,     8'h00, 1'b0, 1'b1, 1'b1, 1'b1);
    apply("R8", 2'd0, 17'h05555, 8'hAA, 1'b1, 1'b1, 1'b1, 1'b1);
    apply("R8", 2'd0, 17'h02AAA, 8'h55, 1'b1, 1'b1, 1'b1, 1'b1);
    apply("R8", 2'd0, 17'h05555, 8'hA0, 1'b1, 1'b0, 1'b1, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R9", "prot_on_o after warm reset", prot_on_o, 1'b1);
    chk("R9", "commit_block_o after warm reset", commit_block_o, 1'b1);
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    chk("R9", "prot_on_o after power-on reset", prot_on_o, 1'b0);
    chk("R1", "commit_block_o after power-on reset", commit_block_o, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule